// File: doc/BRIEF.md
# Sign-Magnitude Adder

This block adds two sign-magnitude operands and returns their sum in the same format. Each operand carries a sign in its top bit (0 positive, 1 negative) and an unsigned magnitude in the bits below it. The block is purely combinational, with no clock and no reset. A downstream stage samples `z` in whatever cycle the operands are valid.

A single add/subtract unit serves both cases. When the two signs match, the magnitudes are added. When they differ, the smaller magnitude is subtracted from the larger. A magnitude comparator orders the operands so that the larger one always reaches the minuend port. A small sign selector then picks the result sign. A zero result is always reported as positive zero. A carry out of the top magnitude bit is dropped.

Parameters set the magnitude width and select the adder and comparator architectures. The adder is either behavioural or a generated ripple chain. The comparator is either a relational compare or a generated LSB-to-MSB decision chain.

Top module: `sm_adder`

## Requirements
- R1: When the sign bits (bit MAG_W) of `x` and `y` are equal, the magnitude of `z` (bits MAG_W-1..0) equals the sum of the two magnitudes modulo 2^MAG_W.
- R2: When the sign bits differ, the magnitude of `z` equals the larger magnitude minus the smaller one.
- R3: When the signs are equal and the result magnitude is nonzero, the sign of `z` equals that common sign.
- R4: When the signs differ and the result magnitude is nonzero, the sign of `z` equals the sign of the operand with the larger magnitude.
- R5: Whenever the result magnitude is zero, `z` is all zeros (positive zero). This includes equal magnitudes with opposite signs, two zero operands of either sign, and a truncated carry.
- R6: The result is commutative: swapping `x` and `y` leaves `z` unchanged.
- R7: For every operand pair whose signed sum fits within the magnitude range, `z` encodes exactly that signed sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | MAG_W+1 | First operand: sign at bit MAG_W, magnitude below it |
| y | input | MAG_W+1 | Second operand, same layout |
| z | output | MAG_W+1 | Sign-magnitude sum, same layout |

## Verification
The bench builds two instances side by side, both with MAG_W = 4. The first uses the behavioural adder and the relational comparator. The second uses the generated ripple adder and the decision-chain comparator, so both generate variants face the same stimulus. At 4 bits of magnitude, all 1024 operand pairs can be swept. That brings every tie, every signed-zero combination and every truncating carry within reach, and the results are checked against integer arithmetic and against the swapped pair.

// File: rtl/sm_adder_pkg.sv
package sm_adder_pkg;
   // adder architecture selectors
   localparam int ADD_BEHAV  = 0;
   localparam int ADD_RIPPLE = 1;
   // comparator architecture selectors
   localparam int CMP_REL    = 0;
   localparam int CMP_CHAIN  = 1;
   // smallest magnitude width supported
   localparam int MIN_MAG_W  = 2;
endpackage

// File: rtl/sm_mag_compare.sv
module sm_mag_compare #(
   parameter int MAG_W = 4,
   parameter int ARCH  = 0
) (
   input  logic [MAG_W-1:0] mag_x,
   input  logic [MAG_W-1:0] mag_y,
   output logic             x_ge_y
);
   import sm_adder_pkg::*;

   generate
      if (ARCH == CMP_REL) begin : g_rel
         assign x_ge_y = (mag_x >= mag_y);
      end else if (ARCH == CMP_CHAIN) begin : g_chain
         // decision from LSB upward: a higher differing bit overrides lower ones
         logic [MAG_W:0] dec;
         assign dec[0] = 1'b1;
         for (genvar i = 0; i < MAG_W; i++) begin : g_bit
            assign dec[i+1] = (mag_x[i] & ~mag_y[i]) |
                              (~(mag_x[i] ^ mag_y[i]) & dec[i]);
         end
         assign x_ge_y = dec[MAG_W];
      end else begin : g_bad
         $error("sm_mag_compare: unknown ARCH %0d", ARCH);
      end
   endgenerate
endmodule

// File: rtl/sm_operand_steer.sv
module sm_operand_steer #(
   parameter int MAG_W = 4
) (
   input  logic [MAG_W-1:0] mag_x,
   input  logic [MAG_W-1:0] mag_y,
   input  logic             x_ge_y,
   output logic [MAG_W-1:0] port_a,
   output logic [MAG_W-1:0] port_b
);
   always_comb begin
      if (x_ge_y) begin
         port_a = mag_x;
         port_b = mag_y;
      end else begin
         port_a = mag_y;
         port_b = mag_x;
      end
   end

   // the minuend port always holds the larger magnitude
   always_comb begin
      AST_MINUEND_LARGER: assert (port_a >= port_b); // R2
   end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
   parameter int MAG_W = 4,
   parameter int ARCH  = 0
) (
   input  logic [MAG_W-1:0] a,
   input  logic [MAG_W-1:0] b,
   input  logic             sub,
   output logic [MAG_W-1:0] r
);
   import sm_adder_pkg::*;

   generate
      if (ARCH == ADD_BEHAV) begin : g_behav
         assign r = sub ? (a - b) : (a + b);
      end else if (ARCH == ADD_RIPPLE) begin : g_ripple
         logic [MAG_W-1:0] b_eff;
         logic [MAG_W-1:0] cy;
         assign b_eff = b ^ {MAG_W{sub}};
         assign cy[0] = sub;
         for (genvar i = 0; i < MAG_W; i++) begin : g_fa
            assign r[i] = a[i] ^ b_eff[i] ^ cy[i];
            if (i < MAG_W - 1) begin : g_cy
               assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
            end
         end
      end else begin : g_bad
         $error("sm_addsub: unknown ARCH %0d", ARCH);
      end
   endgenerate

   // inverse-operation checks: undoing the operation recovers the minuend
   always_comb begin
      if (sub) begin
         AST_SUB_INVERSE: assert (MAG_W'(r + b) == a); // R2
      end else begin
         AST_ADD_INVERSE: assert (MAG_W'(r - b) == a); // R1
      end
   end
endmodule

// File: rtl/sm_sign_select.sv
module sm_sign_select #(
   parameter int MAG_W = 4
) (
   input  logic             sign_x,
   input  logic             sign_y,
   input  logic             x_ge_y,
   input  logic [MAG_W-1:0] mag_res,
   output logic             sign_res
);
   logic differ;
   logic raw;

   assign differ = sign_x ^ sign_y;

   always_comb begin
      if (differ) raw = x_ge_y ? sign_x : sign_y;
      else        raw = sign_x;
      sign_res = (mag_res == '0) ? 1'b0 : raw;
   end
endmodule

// File: rtl/sm_adder.sv
module sm_adder #(
   parameter int MAG_W    = 4,
   parameter int ADD_ARCH = 0,
   parameter int CMP_ARCH = 0
) (
   input  logic [MAG_W:0] x,
   input  logic [MAG_W:0] y,
   output logic [MAG_W:0] z
);
   import sm_adder_pkg::*;

   localparam int SIGN_BIT = MAG_W;

   generate
      if (MAG_W < MIN_MAG_W) begin : g_w_chk
         $error("sm_adder: MAG_W %0d below minimum", MAG_W);
      end
   endgenerate

   logic             sx, sy;
   logic [MAG_W-1:0] mx, my;
   logic             op_sub;
   logic             ge;
   logic [MAG_W-1:0] pa, pb;
   logic [MAG_W-1:0] mres;
   logic             sres;

   assign sx = x[SIGN_BIT];
   assign sy = y[SIGN_BIT];
   assign mx = x[MAG_W-1:0];
   assign my = y[MAG_W-1:0];

   // differing signs select subtraction
   assign op_sub = sx ^ sy;

   sm_mag_compare #(.MAG_W(MAG_W), .ARCH(CMP_ARCH)) u_cmp (
      .mag_x (mx),
      .mag_y (my),
      .x_ge_y(ge)
   );

   sm_operand_steer #(.MAG_W(MAG_W)) u_steer (
      .mag_x (mx),
      .mag_y (my),
      .x_ge_y(ge),
      .port_a(pa),
      .port_b(pb)
   );

   sm_addsub #(.MAG_W(MAG_W), .ARCH(ADD_ARCH)) u_au (
      .a  (pa),
      .b  (pb),
      .sub(op_sub),
      .r  (mres)
   );

   sm_sign_select #(.MAG_W(MAG_W)) u_sign (
      .sign_x  (sx),
      .sign_y  (sy),
      .x_ge_y  (ge),
      .mag_res (mres),
      .sign_res(sres)
   );

   assign z = {sres, mres};

   always_comb begin
      if (z[MAG_W-1:0] == '0) begin
         AST_ZERO_POSITIVE: assert (z[SIGN_BIT] == 1'b0); // R5
      end
      if (sx == sy && z[MAG_W-1:0] != '0) begin
         AST_COMMON_SIGN: assert (z[SIGN_BIT] == sx); // R3
      end
      if (sx != sy && mx > my) begin
         AST_LARGER_SIGN: assert (z[SIGN_BIT] == sx); // R4
      end
      if (sx != sy && my > mx) begin
         AST_LARGER_SIGN_Y: assert (z[SIGN_BIT] == sy); // R4
      end
   end
endmodule

// File: tb/test_sm_adder.sv
module test_sm_adder;
   localparam int W = 4;
   localparam int N = W + 1;
   localparam int P = 1 << N;
   localparam int MAXM = (1 << W) - 1;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [N-1:0] x, y;
   logic [N-1:0] z_b, z_r;
   logic [N-1:0] res_b [P][P];
   logic [N-1:0] res_r [P][P];

   int compared   = 0;
   int mismatched = 0;
   bit done       = 1'b0;

   sm_adder #(.MAG_W(W), .ADD_ARCH(0), .CMP_ARCH(0)) i_sm_adder (
      .x(x), .y(y), .z(z_b));

   sm_adder #(.MAG_W(W), .ADD_ARCH(1), .CMP_ARCH(1)) i_sm_adder_rip (
      .x(x), .y(y), .z(z_r));

   task automatic check(input string req, input string inst,
                        input logic [N-1:0] act, input logic [N-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s x=%b y=%b actual=%b expected=%b",
                  req, inst, x, y, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   task automatic check_pair(input string inst, input logic [N-1:0] zz);
      logic sx, sy, es;
      int mx, my, em, vx, vy, s;
      sx = x[W]; sy = y[W];
      mx = int'(x[W-1:0]); my = int'(y[W-1:0]);
      if (sx == sy) em = (mx + my) % (MAXM + 1);
      else em = (mx >= my) ? mx - my : my - mx;
      if (em == 0)       es = 1'b0;
      else if (sx == sy) es = sx;
      else               es = (mx > my) ? sx : sy;
      if (sx == sy) check("R1", inst, {1'b0, zz[W-1:0]}, {1'b0, W'(em)});
      else          check("R2", inst, {1'b0, zz[W-1:0]}, {1'b0, W'(em)});
      if (em != 0) begin
         if (sx == sy) check("R3", inst, {zz[W], {W{1'b0}}}, {es, {W{1'b0}}});
         else          check("R4", inst, {zz[W], {W{1'b0}}}, {es, {W{1'b0}}});
      end else begin
         check("R5", inst, zz, '0);
      end
      vx = sx ? -mx : mx;
      vy = sy ? -my : my;
      s  = vx + vy;
      if (s <= MAXM && s >= -MAXM)
         check("R7", inst, zz, {s < 0, W'((s < 0) ? -s : s)});
   endtask

   initial begin
      x = '0; y = '0;
      @(posedge clk);
      @(negedge clk);
      check("R5 zero inputs", "behav", z_b, '0);
      check("R5 zero inputs", "ripple", z_r, '0);
      for (int i = 0; i < P; i++) begin
         for (int j = 0; j < P; j++) begin
            @(posedge clk);
            x = N'(i); y = N'(j);
            @(negedge clk);
            check_pair("behav", z_b);
            check_pair("ripple", z_r);
            res_b[i][j] = z_b;
            res_r[i][j] = z_r;
         end
      end
      // commutativity
      for (int i = 0; i < P; i++) begin
         for (int j = i + 1; j < P; j++) begin
            x = N'(i); y = N'(j);
            check("R6", "behav", res_b[j][i], res_b[i][j]);
            check("R6", "ripple", res_r[j][i], res_r[i][j]);
         end
      end
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog expired");
         summary();
      end
   end
endmodule